// File: doc/BRIEF.md
# Parallel Converter Frame Reader

This block is the host-side master for a multichannel data converter that presents its results on a 16-bit parallel bus. A start command arms it. It then waits until the converter's busy line reports that conversion results are ready. After that it drives an active-low chip-select and one active-low read strobe per channel. At the end of each read-low phase it stores the word on the bus into an indexed result buffer.

While reading, the block watches the converter's first-channel flag. That flag must be high for the first word of the frame and low for every later word. Any mismatch sets a sticky sync-error bit, which signals that the host and the converter no longer agree on channel order. After the last word the block pulses frame-done for one cycle.

The block supports two strobe wirings. In the separate wiring, chip-select brackets the whole frame. In the tied wiring, chip-select and read toggle together for each word. The read-low and read-high durations are set by runtime counts of system clocks.

Top module: `adc_par_reader`

## Requirements
- R1: After reset, cs_n and rd_n are high, frame_done and sync_err are low, and every result slot reads zero.
- R2: After an accepted start, rd_n stays high for as long as busy is high, and reading begins only once busy is low.
- R3: Each frame issues exactly NUM_CH read-low pulses. Slot k (bits [k*DATA_W +: DATA_W], with slot 0 holding the first channel) holds the bus word present at the end of the k-th read-low pulse.
- R4: Each read-low pulse lasts max(rd_lo_cycles, 2) clocks. Between two pulses of a frame, rd_n stays high for max(rd_hi_cycles, 2) clocks.
- R5: With tied_mode = 0, cs_n falls at least one clock before the first read pulse and stays low throughout the frame. It rises only in the cycle that frame_done is high.
- R6: With tied_mode = 1, cs_n equals rd_n in every cycle.
- R7: After the high phase that follows the last word, frame_done is high for exactly one clock. In that clock cs_n is high.
- R8: sync_err is set if first_flag is low at the capture of word 0, or high at the capture of any later word. Once set, it stays set until the next accepted start.
- R9: An accepted start clears sync_err in the following clock. A frame whose flags are all correct leaves sync_err low.
- R10: A start raised while a frame is in progress is ignored. The frame still issues NUM_CH pulses and one frame_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms one frame read; accepted only when idle |
| tied_mode | input | 1 | 1: chip-select follows read; 0: chip-select brackets the frame |
| rd_lo_cycles | input | CNT_W | Read-low duration in clocks (values below 2 act as 2) |
| rd_hi_cycles | input | CNT_W | Read-high duration in clocks (values below 2 act as 2) |
| busy | input | 1 | Converter busy; reading waits while high |
| adc_data | input | DATA_W | Converter parallel data bus |
| first_flag | input | 1 | Converter first-channel indicator |
| cs_n | output | 1 | Active-low chip-select to the converter |
| rd_n | output | 1 | Active-low read strobe to the converter |
| results | output | NUM_CH*DATA_W | Captured words, slot k at bits [k*DATA_W +: DATA_W] |
| frame_done | output | 1 | One-clock pulse after the last word |
| sync_err | output | 1 | Sticky first-channel flag mismatch |

## Verification
The bench builds the block with NUM_CH = 8, DATA_W = 16 and CNT_W = 4. This keeps the strobe counts small enough to sweep the clamped values 0 and 1 alongside longer phases such as 5 and 7 within a short run. With eight channels, a flag fault can be placed on the first word, on a middle word and on the last word. That in turn exercises both the sticky set and the clear on the next start. Both strobe wirings run with the same converter model, so their chip-select behaviour is compared directly.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_SETUP = 3'd2,
    ST_RLO   = 3'd3,
    ST_RHI   = 3'd4
  } rd_state_e;

  localparam int unsigned MIN_PHASE = 2;
endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  import adc_rd_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] eff;

  // Durations under the minimum are stretched to it
  always_comb begin
    eff = (limit < CNT_W'(MIN_PHASE)) ? CNT_W'(MIN_PHASE) : limit;
    last = run && (cnt_q == eff - CNT_W'(1));
    if (!run || last) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_CH*DATA_W-1:0] rd_flat
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              slot_en;

    assign slot_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= wr_data;
    end

    assign rd_flat[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/adc_read_fsm.sv
module adc_read_fsm #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   tied_mode,
  input  logic                   busy,
  input  logic                   first_flag,
  input  logic                   ph_last,
  output adc_rd_pkg::rd_state_e  state,
  output logic                   wr_en,
  output logic [IDX_W-1:0]       wr_idx,
  output logic                   cs_n,
  output logic                   rd_n,
  output logic                   frame_done,
  output logic                   sync_err
);
  import adc_rd_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

  rd_state_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cs_q, cs_d, rd_q, rd_d, done_q, done_d, err_q, err_d;
  logic             accept;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    err_d  = err_q;
    accept = 1'b0;
    wr_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        accept = 1'b1;
        idx_d  = '0;
        st_d   = ST_WAIT;
      end
      ST_WAIT:  if (!busy) st_d = tied_mode ? ST_RLO : ST_SETUP;
      ST_SETUP: st_d = ST_RLO;
      ST_RLO: if (ph_last) begin
        wr_en = 1'b1;
        st_d  = ST_RHI;
      end
      ST_RHI: if (ph_last) begin
        if (idx_q == LAST_IDX) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + IDX_W'(1);
          st_d  = ST_RLO;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    // Word 0 must carry the flag, every later word must not
    if (accept) err_d = 1'b0;
    else if (wr_en && (first_flag != (idx_q == '0))) err_d = 1'b1;

    // Strobes are registered from the next state so they never glitch
    rd_d = (st_d != ST_RLO);
    unique case (st_d)
      ST_SETUP, ST_RLO: cs_d = 1'b0;
      ST_RHI:           cs_d = tied_mode;
      default:          cs_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cs_q   <= 1'b1;
      rd_q   <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      cs_q   <= cs_d;
      rd_q   <= rd_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign state      = st_q;
  assign wr_idx     = idx_q;
  assign cs_n       = cs_q;
  assign rd_n       = rd_q;
  assign frame_done = done_q;
  assign sync_err   = err_q;
endmodule

// File: rtl/adc_par_reader.sv
module adc_par_reader #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     tied_mode,
  input  logic [CNT_W-1:0]         rd_lo_cycles,
  input  logic [CNT_W-1:0]         rd_hi_cycles,
  input  logic                     busy,
  input  logic [DATA_W-1:0]        adc_data,
  input  logic                     first_flag,
  output logic                     cs_n,
  output logic                     rd_n,
  output logic [NUM_CH*DATA_W-1:0] results,
  output logic                     frame_done,
  output logic                     sync_err
);
  import adc_rd_pkg::*;

  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  rd_state_e        state;
  logic             ph_run, ph_last, wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [CNT_W-1:0] ph_limit;

  assign ph_run   = (state == ST_RLO) || (state == ST_RHI);
  assign ph_limit = (state == ST_RLO) ? rd_lo_cycles : rd_hi_cycles;

  adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ph_run),
    .limit (ph_limit),
    .last  (ph_last)
  );

  adc_read_fsm #(.NUM_CH(NUM_CH)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tied_mode  (tied_mode),
    .busy       (busy),
    .first_flag (first_flag),
    .ph_last    (ph_last),
    .state      (state),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .frame_done (frame_done),
    .sync_err   (sync_err)
  );

  adc_result_buf #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (adc_data),
    .rd_flat (results)
  );
endmodule

// File: rtl/adc_par_reader_chk.sv
module adc_par_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic tied_mode,
  input logic cs_n,
  input logic rd_n,
  input logic frame_done,
  input logic sync_err
);
  // R6: tied wiring keeps both strobes equal
  p_tied_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tied_mode |-> (cs_n == rd_n));

  // R5: a read pulse never occurs without chip-select
  p_rd_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);

  // R4: read-low lasts at least two clocks
  p_min_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);

  // R4: read-high lasts at least two clocks
  p_min_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |=> rd_n);

  // R7: frame-done is a single clock and the bus is released
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_done_cs_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> cs_n);

  // R8: sync error holds until a start is seen
  p_sync_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !start) |=> sync_err);
endmodule

bind adc_par_reader adc_par_reader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .tied_mode  (tied_mode),
  .cs_n       (cs_n),
  .rd_n       (rd_n),
  .frame_done (frame_done),
  .sync_err   (sync_err)
);

// File: tb/adc_par_reader_bench.sv
module adc_par_reader_bench;
  localparam int NUM_CH = 8;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 4;

  logic                     clk, rst_n, start, tied_mode, busy, first_flag;
  logic [CNT_W-1:0]         rd_lo_cycles, rd_hi_cycles;
  logic [DATA_W-1:0]        adc_data;
  logic                     cs_n, rd_n, frame_done, sync_err;
  logic [NUM_CH*DATA_W-1:0] results;

  int checks = 0, fails = 0, cycles = 0;
  int conv_k, bad_idx, seed;
  int mon_falls, mon_dones, lo_run, hi_run, lo_min, lo_max, hi_min, hi_max;
  int tie_bad, cs_gap, pre_cs_bad, done_cs_bad;
  logic prev_rd, prev_cs, in_frame;

  adc_par_reader #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_adc_par_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .tied_mode(tied_mode),
    .rd_lo_cycles(rd_lo_cycles), .rd_hi_cycles(rd_hi_cycles), .busy(busy),
    .adc_data(adc_data), .first_flag(first_flag), .cs_n(cs_n), .rd_n(rd_n),
    .results(results), .frame_done(frame_done), .sync_err(sync_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DATA_W-1:0] pat(int k, int s);
    return DATA_W'((s * 16'h1357 + k * 16'h0F21) ^ (k << 9));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Converter model: a new word appears on each falling read edge
  always @(negedge rd_n) begin
    adc_data   = pat(conv_k, seed);
    first_flag = (conv_k == 0) ^ (conv_k == bad_idx);
    conv_k++;
  end

  // Strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (!rd_n && prev_rd) begin
        if (mon_falls == 0) begin
          if (tied_mode ? (prev_cs !== 1'b1) : (prev_cs !== 1'b0)) pre_cs_bad++;
        end else begin
          if (hi_run < hi_min) hi_min = hi_run;
          if (hi_run > hi_max) hi_max = hi_run;
        end
        mon_falls++;
        lo_run = 1;
        in_frame = 1'b1;
      end else if (!rd_n) lo_run++;
      if (rd_n && !prev_rd) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
        hi_run = 1;
      end else if (rd_n && in_frame) hi_run++;
      if (tied_mode && (cs_n !== rd_n)) tie_bad++;
      if (!tied_mode && in_frame && cs_n && !frame_done) cs_gap++;
      if (frame_done) begin
        mon_dones++;
        if (!cs_n) done_cs_bad++;
        in_frame = 1'b0;
      end
    end
    prev_rd = rd_n;
    prev_cs = cs_n;
  end

  // Watchdog: counts as a failure and still reports
  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; tied_mode = 1'b0; busy = 1'b1;
    rd_lo_cycles = 2; rd_hi_cycles = 2; adc_data = '0; first_flag = 1'b0;
    conv_k = 0; bad_idx = NUM_CH; seed = 1;
    prev_rd = 1'b1; prev_cs = 1'b1; in_frame = 1'b0;
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
    check(rd_n === 1'b1, "R1", "rd_n in reset", int'(rd_n), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(frame_done === 1'b0, "R1", "frame_done after reset", int'(frame_done), 0);
    check(sync_err === 1'b0, "R1", "sync_err after reset", int'(sync_err), 0);
    check(results === '0, "R1", "results after reset", int'(results[15:0]), 0);
  endtask

  task automatic t_frame(bit tied, int lo, int hi, int bad, int hold, bit mid_start, int s);
    int exp_lo, exp_hi, n, hold_bad;
    exp_lo = (lo < 2) ? 2 : lo;
    exp_hi = (hi < 2) ? 2 : hi;
    tied_mode = tied; rd_lo_cycles = CNT_W'(lo); rd_hi_cycles = CNT_W'(hi);
    bad_idx = bad; seed = s; conv_k = 0;
    mon_falls = 0; mon_dones = 0; lo_min = 1000; lo_max = 0; hi_min = 1000; hi_max = 0;
    tie_bad = 0; cs_gap = 0; pre_cs_bad = 0; done_cs_bad = 0; hold_bad = 0;
    busy = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(sync_err === 1'b0, "R9", "sync_err after start", int'(sync_err), 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (rd_n !== 1'b1) hold_bad++;
    end
    check(hold_bad == 0, "R2", "read strobes while busy", hold_bad, 0);
    busy = 1'b0;
    n = 0;
    while (mon_dones == 0 && n < 2000) begin
      @(negedge clk);
      if (mid_start && mon_falls == 3) start = 1'b1;
      else start = 1'b0;
      n++;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(mon_falls == NUM_CH, mid_start ? "R10" : "R3", "read pulses", mon_falls, NUM_CH);
    check(mon_dones == 1, mid_start ? "R10" : "R7", "frame_done pulses", mon_dones, 1);
    check(done_cs_bad == 0, "R7", "cs_n low at frame_done", done_cs_bad, 0);
    check(lo_min == exp_lo && lo_max == exp_lo, "R4", "read-low width", lo_max, exp_lo);
    check(hi_min == exp_hi && hi_max == exp_hi, "R4", "read-high width", hi_max, exp_hi);
    if (tied) check(tie_bad == 0, "R6", "cs_n differs from rd_n", tie_bad, 0);
    else begin
      check(pre_cs_bad == 0, "R5", "cs_n not low before first read", pre_cs_bad, 0);
      check(cs_gap == 0, "R5", "cs_n high inside frame", cs_gap, 0);
    end
    check(sync_err === (bad < NUM_CH), (bad < NUM_CH) ? "R8" : "R9", "sync_err after frame",
          int'(sync_err), int'(bad < NUM_CH));
    for (int k = 0; k < NUM_CH; k++)
      check(results[k*DATA_W +: DATA_W] === pat(k, s), "R3", $sformatf("slot %0d", k),
            int'(results[k*DATA_W +: DATA_W]), int'(pat(k, s)));
  endtask

  task automatic t_sticky_hold();
    // R8: sync_err stays set while idle with no start
    repeat (10) @(negedge clk);
    check(sync_err === 1'b1, "R8", "sync_err held while idle", int'(sync_err), 1);
  endtask

  initial begin
    t_reset();
    t_frame(1'b0, 3, 2, NUM_CH, 5, 1'b0, 7);
    t_frame(1'b1, 2, 3, NUM_CH, 0, 1'b0, 11);
    t_frame(1'b0, 0, 1, NUM_CH, 2, 1'b0, 13);
    t_frame(1'b1, 5, 7, 0, 3, 1'b0, 17);
    t_sticky_hold();
    t_frame(1'b0, 2, 2, NUM_CH, 4, 1'b0, 19);
    t_frame(1'b0, 4, 2, 3, 1, 1'b0, 23);
    t_frame(1'b1, 2, 2, NUM_CH - 1, 2, 1'b0, 29);
    t_frame(1'b0, 3, 3, NUM_CH, 2, 1'b1, 31);
    t_frame(1'b1, 2, 4, NUM_CH, 2, 1'b1, 37);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule